// File: doc/BRIEF.md
# Handshaked PHY Control-Bus Master

This block drives the 16-bit register bus that configures a serial-link PHY. On the PHY side there is one outbound data word (`phy_din`), four strobes and a single acknowledge line (`phy_ack`). The PHY returns a word on `phy_dout` while it acknowledges a read. An access is built from phases. Each phase puts a value on `phy_din`, raises exactly one strobe, waits for `phy_ack` to go high, drops the strobe, and waits for `phy_ack` to go low. The strobe is one of: latch address, latch data, read, or commit write. The block sequences these phases in hardware, so the requester issues only one command per access.

Commands arrive on a valid/ready port. The requester sets `cmd_op`, `cmd_addr`, `cmd_wdata` and `cmd_mask` and raises `cmd_valid`. A command is taken on a rising edge when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the block is idle, so back-pressure holds for the whole access. The block does not remember a `cmd_valid` that it sees while busy. The requester must keep the command fields stable until the handshake edge.

When the access ends, `done` pulses for one cycle. `rd_data` and `err` are valid in that cycle. Every wait for the acknowledge line has a limit, set on `tmo_cycles`. If the limit runs out, the access is abandoned and `err` reports the abort.

Top module: `cbm_master`

## Requirements
- R1: After reset, `cmd_ready`=1 and `phy_din`=0. All four strobes, `done` and `err` are 0. A command is taken only while `cmd_ready` is high. `cmd_ready` is low from the cycle after acceptance until the access ends. A `cmd_valid` raised while busy does not start a command and changes no PHY location.
- R2: Address phase: `phy_din` carries the address with no strobe high for at least two cycles. Then `phy_cap_addr` rises.
- R3: At most one strobe is high at a time. A strobe stays high until `phy_ack` is seen high and then falls. No strobe rises in a cycle that follows a cycle with `phy_ack` high.
- R4: `phy_din` never changes in a cycle in which any strobe rises or falls.
- R5: A read (`cmd_op`=00, and the spare code 11 behaves the same) runs in this order: address phase, one cycle with `phy_din` at zero and all strobes low, then a handshake on `phy_rd`. `rd_data` is the `phy_dout` value present while `phy_ack` was high.
- R6: A write (`cmd_op`=01) runs in this order: address phase, then a data phase, then a handshake on `phy_wr` with the data still on `phy_din`. In the data phase, `phy_din` carries the data for at least two cycles with no strobe, then a handshake on `phy_cap_data` follows. The PHY location then holds the data.
- R7: A read-modify-write (`cmd_op`=10) first performs a full read of the location. It then performs a full write of `(old & ~cmd_mask) | cmd_wdata` to the same address. `rd_data` reports the old value.
- R8: Each wait counts cycles from 0 from the cycle its state is entered. It aborts when `phy_ack` has not reached the awaited level in the cycle whose count equals `tmo_cycles`. An acknowledge that arrives in that same cycle wins. On abort, the block returns to idle with all strobes low and pulses `done` with `err`=1.
- R9: `done` is high for exactly one cycle per command. `err`=0 after a completed access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 2 | 00 read, 01 write, 10 read-modify-write, 11 read |
| cmd_addr | input | DW | PHY register address |
| cmd_wdata | input | DW | Write value, or value ORed in by read-modify-write |
| cmd_mask | input | DW | Bits cleared by read-modify-write |
| tmo_cycles | input | TW | Acknowledge wait limit in cycles |
| phy_din | output | DW | Outbound address/data word |
| phy_cap_addr | output | 1 | Latch-address strobe |
| phy_cap_data | output | 1 | Latch-data strobe |
| phy_rd | output | 1 | Read strobe |
| phy_wr | output | 1 | Commit-write strobe |
| phy_dout | input | DW | Word returned by the PHY |
| phy_ack | input | 1 | PHY acknowledge |
| done | output | 1 | One-cycle end-of-command pulse |
| rd_data | output | DW | Read result, valid with `done` |
| err | output | 1 | Abort flag, valid with `done` |

## Verification
The timeout counter reaching its limit and the acknowledge arriving can coincide in the same cycle. A behavioural PHY model with a programmable response delay provokes this. With a delay of two cycles, the acknowledge is first visible at count 3. A limit of 3 must then complete cleanly, and a limit of 2 must abort. The bench judges the result from `err` and from a later read-back of the target location. A second coincidence is `done` together with the return of `cmd_ready`. The bench issues each command right after the previous done pulse, sweeping every address under four response delays.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_RMW   = 2'b10,
    OP_SPARE = 2'b11
  } op_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ASET, S_ASTB, S_AREL,
    S_RGAP, S_RSTB, S_RREL,
    S_DSET, S_DSTB, S_DREL,
    S_WSTB, S_WREL
  } st_t;
endpackage

// File: rtl/cbm_stepcnt.sv
module cbm_stepcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  // cycles spent in the current state, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cbm_merge.sv
module cbm_merge #(
  parameter int W = 16
) (
  input  logic [W-1:0] old_val,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] set_val,
  output logic [W-1:0] result
);
  assign result = (old_val & ~clr_mask) | set_val;
endmodule

// File: rtl/cbm_master.sv
module cbm_master #(
  parameter int DW        = 16,
  parameter int TW        = 16,
  parameter int SETUP_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [DW-1:0] cmd_mask,
  input  logic [TW-1:0] tmo_cycles,
  output logic [DW-1:0] phy_din,
  output logic          phy_cap_addr,
  output logic          phy_cap_data,
  output logic          phy_rd,
  output logic          phy_wr,
  input  logic [DW-1:0] phy_dout,
  input  logic          phy_ack,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          err
);
  import cbm_pkg::*;

  localparam logic [TW-1:0] SET_LAST = TW'(SETUP_CYC - 1);

  st_t          st_q, st_d;
  op_t          op_q;
  logic [DW-1:0] addr_q, wdata_q, mask_q, rdat_q, din_q, merged;
  logic [3:0]   stb_q;             // {cap_addr, cap_data, rd, wr}
  logic         done_q, err_q;
  logic         finish, fail, grab, accept, expired;
  logic [TW-1:0] cnt;

  cbm_stepcnt #(.W(TW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_d != st_q),
    .cnt   (cnt)
  );

  cbm_merge #(.W(DW)) u_merge (
    .old_val  (rdat_q),
    .clr_mask (mask_q),
    .set_val  (wdata_q),
    .result   (merged)
  );

  assign accept  = cmd_valid && (st_q == S_IDLE);
  assign expired = (cnt >= tmo_cycles);

  always_comb begin
    st_d   = st_q;
    finish = 1'b0;
    fail   = 1'b0;
    grab   = 1'b0;
    case (st_q)
      S_IDLE: if (cmd_valid) st_d = S_ASET;
      S_ASET: if (cnt == SET_LAST) st_d = S_ASTB;
      S_ASTB: if (phy_ack) st_d = S_AREL; else if (expired) fail = 1'b1;
      S_AREL: if (!phy_ack) st_d = (op_q == OP_WRITE) ? S_DSET : S_RGAP;
              else if (expired) fail = 1'b1;
      S_RGAP: st_d = S_RSTB;
      S_RSTB: if (phy_ack) begin grab = 1'b1; st_d = S_RREL; end
              else if (expired) fail = 1'b1;
      S_RREL: if (!phy_ack) begin
                if (op_q == OP_RMW) st_d = S_ASET;
                else finish = 1'b1;
              end else if (expired) fail = 1'b1;
      S_DSET: if (cnt == SET_LAST) st_d = S_DSTB;
      S_DSTB: if (phy_ack) st_d = S_DREL; else if (expired) fail = 1'b1;
      S_DREL: if (!phy_ack) st_d = S_WSTB; else if (expired) fail = 1'b1;
      S_WSTB: if (phy_ack) st_d = S_WREL; else if (expired) fail = 1'b1;
      S_WREL: if (!phy_ack) finish = 1'b1; else if (expired) fail = 1'b1;
      default: st_d = S_IDLE;
    endcase
    if (finish || fail) st_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      op_q    <= OP_READ;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      rdat_q  <= '0;
      din_q   <= '0;
      stb_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish | fail;
      if (accept) begin
        op_q    <= op_t'(cmd_op);
        addr_q  <= cmd_addr;
        wdata_q <= cmd_wdata;
        mask_q  <= cmd_mask;
        err_q   <= 1'b0;
      end
      if (fail) err_q <= 1'b1;
      if (grab) rdat_q <= phy_dout;
      if (st_q == S_RREL && st_d == S_ASET) begin
        wdata_q <= merged;
        op_q    <= OP_WRITE;
      end
      // outbound word only moves while every strobe is low
      if (st_d == S_ASET && st_q != S_ASET)
        din_q <= (st_q == S_IDLE) ? cmd_addr : addr_q;
      else if (st_d == S_DSET && st_q != S_DSET)
        din_q <= wdata_q;
      else if (st_d == S_RGAP)
        din_q <= '0;
      stb_q <= {st_d == S_ASTB, st_d == S_DSTB, st_d == S_RSTB, st_d == S_WSTB};
    end
  end

  assign cmd_ready    = (st_q == S_IDLE);
  assign phy_din      = din_q;
  assign phy_cap_addr = stb_q[3];
  assign phy_cap_data = stb_q[2];
  assign phy_rd       = stb_q[1];
  assign phy_wr       = stb_q[0];
  assign done         = done_q;
  assign rd_data      = rdat_q;
  assign err          = err_q;

  logic any_stb;
  assign any_stb = |stb_q;

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb_q));

  // R3
  rise_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_stb) |-> !$past(phy_ack));

  // R4
  din_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q != $past(stb_q)) |-> $stable(phy_din));

  // R1
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  // R8
  quiet_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !any_stb);
endmodule

// File: tb/tb_cbm_master.sv
module tb_cbm_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'b00;
  logic [15:0] cmd_addr = '0, cmd_wdata = '0, cmd_mask = '0;
  logic [15:0] tmo_cycles = 16'd8;
  logic [15:0] phy_din, phy_dout;
  logic        phy_cap_addr, phy_cap_data, phy_rd, phy_wr, phy_ack;
  logic        done, err;
  logic [15:0] rd_data;

  always #10 clk = ~clk;

  cbm_master dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_mask(cmd_mask),
    .tmo_cycles(tmo_cycles), .phy_din(phy_din), .phy_cap_addr(phy_cap_addr),
    .phy_cap_data(phy_cap_data), .phy_rd(phy_rd), .phy_wr(phy_wr),
    .phy_dout(phy_dout), .phy_ack(phy_ack), .done(done), .rd_data(rd_data), .err(err)
  );

  int errors = 0;
  int checks = 0;

  // ---------------- behavioural PHY ----------------
  int          dly = 0;
  bit          stuck = 1'b0;
  bit          abort_ok = 1'b0;
  logic [15:0] mem [16];
  logic [15:0] maddr, mdata;
  int          dcnt;
  logic        stb;
  assign stb = phy_cap_addr | phy_cap_data | phy_rd | phy_wr;

  function automatic logic [15:0] init_val(input int i);
    return 16'h3C00 + 16'(i * 16'h0111);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      phy_ack  <= 1'b0;
      phy_dout <= '0;
      dcnt     <= 0;
      maddr    <= '0;
      mdata    <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= init_val(i);
    end else if (stb != phy_ack && !(stuck && stb)) begin
      if (dcnt >= dly) begin
        phy_ack <= stb;
        dcnt    <= 0;
        if (stb) begin
          if (phy_cap_addr) maddr <= phy_din;
          if (phy_cap_data) mdata <= phy_din;
          if (phy_wr)       mem[maddr[3:0]] <= mdata;
          if (phy_rd)       phy_dout <= mem[maddr[3:0]];
        end
      end else dcnt <= dcnt + 1;
    end else dcnt <= 0;
  end

  // ---------------- protocol monitor ----------------
  int v_r2 = 0, v_r3 = 0, v_r4 = 0, v_r5 = 0;
  logic [15:0] pdin = '0;
  logic [3:0]  pstb = '0;
  logic        pack = 1'b0;
  int          hold = 0;

  always @(negedge clk) begin
    logic [3:0] sv;
    if (rst_n) begin
      sv = {phy_cap_addr, phy_cap_data, phy_rd, phy_wr};
      if (sv != pstb && phy_din != pdin) v_r4++;
      if (((sv[3] && !pstb[3]) || (sv[2] && !pstb[2])) && hold < 2) v_r2++;
      if (sv[1] && !pstb[1] && !(pstb == 0 && pdin == 0 && phy_din == 0)) v_r5++;
      if (pstb != 0 && sv == 0 && !pack && !abort_ok) v_r3++;
      if (sv != 0 && pstb == 0 && pack) v_r3++;
      if ($countones(sv) > 1) v_r3++;
      if (sv == 0) hold = (phy_din == pdin) ? hold + 1 : 1;
      else hold = 0;
      pdin = phy_din;
      pstb = sv;
      pack = phy_ack;
    end
  end

  // ---------------- helpers ----------------
  logic [15:0] gold [16];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [15:0] a, input logic [15:0] w,
                         input logic [15:0] m, output logic [15:0] rdat, output logic e);
    int n;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = w; cmd_mask = m;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    rdat = rd_data;
    e    = err;
    chk(done == 1'b1, "R9 done seen", {31'd0, done}, 32'd1);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] r, v, m;
    logic        e;
    for (int i = 0; i < 16; i++) gold[i] = init_val(i);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1 reset ready", {31'd0, cmd_ready}, 32'd1);
    chk(phy_din == 16'h0, "R1 reset din", {16'd0, phy_din}, 32'd0);
    chk({phy_cap_addr, phy_cap_data, phy_rd, phy_wr, done, err} == 6'b0, "R1 reset outputs",
        {26'd0, phy_cap_addr, phy_cap_data, phy_rd, phy_wr, done, err}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int d = 0; d < 4; d++) begin
      dly = d;
      for (int a = 0; a < 16; a++) begin
        v = 16'h5A00 ^ 16'(a * 16'h0137) ^ 16'(d << 12);
        run_cmd(2'b01, 16'h1000 | 16'(a), v, 16'h0, r, e);
        chk(e == 1'b0, "R6 write no err", {31'd0, e}, 32'd0);
        gold[a] = v;
        run_cmd(2'b00, 16'h1000 | 16'(a), 16'h0, 16'h0, r, e);
        chk(r == gold[a], "R6 R5 read back write", {16'd0, r}, {16'd0, gold[a]});
        chk(e == 1'b0, "R9 read no err", {31'd0, e}, 32'd0);
      end
      for (int a = 1; a < 16; a += 5) begin
        m = 16'h0FF0 >> d;
        v = 16'h8001 | 16'(a << 4);
        run_cmd(2'b10, 16'h2000 | 16'(a), v, m, r, e);
        chk(r == gold[a], "R7 rmw returns old", {16'd0, r}, {16'd0, gold[a]});
        gold[a] = (gold[a] & ~m) | v;
        run_cmd(2'b00, 16'h2000 | 16'(a), 16'h0, 16'h0, r, e);
        chk(r == gold[a], "R7 rmw merged value", {16'd0, r}, {16'd0, gold[a]});
      end
      run_cmd(2'b11, 16'h0003, 16'hFFFF, 16'h0, r, e);
      chk(r == gold[3], "R5 spare code reads", {16'd0, r}, {16'd0, gold[3]});
    end

    // R1: valid while busy is dropped
    dly = 1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 16'h0004; cmd_wdata = 16'h1234;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b0, "R1 busy not ready", {31'd0, cmd_ready}, 32'd0);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 16'h0009; cmd_wdata = 16'hDEAD;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    gold[4] = 16'h1234;
    @(negedge clk);
    run_cmd(2'b00, 16'h0009, 16'h0, 16'h0, r, e);
    chk(r == gold[9], "R1 busy command ignored", {16'd0, r}, {16'd0, gold[9]});
    run_cmd(2'b00, 16'h0004, 16'h0, 16'h0, r, e);
    chk(r == gold[4], "R1 accepted write landed", {16'd0, r}, {16'd0, gold[4]});

    // R8 boundary: ack seen at count 3
    dly = 2; tmo_cycles = 16'd3;
    run_cmd(2'b01, 16'h0007, 16'h7777, 16'h0, r, e);
    chk(e == 1'b0, "R8 ack at limit wins", {31'd0, e}, 32'd0);
    gold[7] = 16'h7777;
    abort_ok = 1'b1;
    tmo_cycles = 16'd2;
    run_cmd(2'b01, 16'h0007, 16'h0BAD, 16'h0, r, e);
    chk(e == 1'b1, "R8 limit one short aborts", {31'd0, e}, 32'd1);
    repeat (6) @(negedge clk);
    tmo_cycles = 16'd8;
    run_cmd(2'b00, 16'h0007, 16'h0, 16'h0, r, e);
    chk(r == gold[7], "R8 aborted write left location", {16'd0, r}, {16'd0, gold[7]});

    // R8 silent PHY
    stuck = 1'b1; tmo_cycles = 16'd5;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b00; cmd_addr = 16'h0002;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(err == 1'b1, "R8 stuck err", {31'd0, err}, 32'd1);
    chk({phy_cap_addr, phy_cap_data, phy_rd, phy_wr} == 4'b0, "R8 strobes low on abort",
        {28'd0, phy_cap_addr, phy_cap_data, phy_rd, phy_wr}, 32'd0);
    chk(cmd_ready == 1'b1, "R8 idle after abort", {31'd0, cmd_ready}, 32'd1);
    stuck = 1'b0; tmo_cycles = 16'd8;
    repeat (4) @(negedge clk);
    abort_ok = 1'b0;
    run_cmd(2'b00, 16'h0002, 16'h0, 16'h0, r, e);
    chk(r == gold[2] && e == 1'b0, "R8 recovers after abort", {15'd0, e, r}, {16'd0, gold[2]});

    chk(v_r2 == 0, "R2 setup hold violations", v_r2, 0);
    chk(v_r3 == 0, "R3 handshake violations", v_r3, 0);
    chk(v_r4 == 0, "R4 din moved with strobe", v_r4, 0);
    chk(v_r5 == 0, "R5 read gap violations", v_r5, 0);
    summary();
  end
endmodule